// File: doc/BRIEF.md
# ATA Strobe Timing Generator

This block drives the active-low read and write strobes of one parallel ATA channel for PIO and multiword DMA cycles. One 32-bit timing word sets the shape of every access. The word is cut into fields, and each field counts clock cycles, stored as the count minus one. Register (task-file) accesses use one pair of active and inactive fields, and data-port accesses use a second pair. Each kind of access also has its own setup field, which sets the delay before the first strobe.

A controller gives a one-cycle request. The request says whether the access is a register or data access and whether it reads or writes. When the block takes the request it copies the timing word. It then runs a setup phase, an active strobe phase and a recovery phase. In the last recovery cycle it pulses `done`. The four enable bits at the top of the word only leave the block as status outputs. A request that arrives in the `done` cycle is taken at once. When that request and the one before it are both data accesses, the setup phase is skipped.

Top module: `ata_strobe_gen`

## Requirements
- R1: After reset, both strobes are high, `busy` and `done` are low, and the four status outputs are 0.
- R2: For a data access, the strobe stays low for (word[8:4] + 1) cycles.
- R3: For a data access, the recovery (strobe high) phase lasts (word[3:0] + 1) cycles.
- R4: For a register access, the active time comes from word[17:13] + 1 and the recovery time from word[12:9] + 1.
- R5: An access taken from idle first holds both strobes high for a setup phase. This phase lasts (word[24:22] + 1) cycles for data and (word[27:25] + 1) cycles for register accesses. It starts in the cycle after the request.
- R6: A read (`reqIsWrite`=0) drives only `rdStrobeN` low, and a write drives only `wrStrobeN` low. Both strobes are high whenever no active phase is in progress.
- R7: `busy` is high from the cycle after acceptance up to the last recovery cycle. In that last cycle `busy` is low and `done` is high for exactly one cycle.
- R8: A request in the `done` cycle is accepted. When both it and the previous access are data accesses, its active phase starts in the next cycle with no setup. Otherwise its setup phase runs as in R5.
- R9: A request while `busy` is high is ignored: the waveform in progress and the status outputs are unchanged, and no extra access follows.
- R10: The timing word and the request kind are captured at acceptance. Changing them during an access has no effect on that access.
- R11: `udmaEn`, `dmaEn`, `pioMasterEn` and `fifoEn` show bits 28, 29, 30 and 31 of the captured word. Those bits, and bits 21:18, do not change the strobe waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | One-cycle access request |
| reqIsReg | input | 1 | 1 = task-file register access, 0 = data-port access |
| reqIsWrite | input | 1 | 1 = write, 0 = read |
| timingWord | input | 32 | Packed timing and enable word |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| busy | output | 1 | Access in progress; requests are ignored |
| done | output | 1 | Last cycle of an access |
| udmaEn | output | 1 | Captured Ultra DMA enable bit |
| dmaEn | output | 1 | Captured DMA enable bit |
| pioMasterEn | output | 1 | Captured bus-master-in-PIO enable bit |
| fifoEn | output | 1 | Captured FIFO enable bit |

## Verification
Data and register accesses are run with timing words whose data fields differ from their register fields. A waveform that picks the wrong field set therefore shows up as a wrong phase length. Reads and writes run with the same word, which separates strobe selection from timing. All-zero and all-maximum words test the one-cycle and widest phases. Chained requests in the `done` cycle cover two cases: data after data, and register after data. These tell the skipped setup apart from the normal one. Requests injected mid-access and a timing word that is scrambled right after acceptance show whether the block ignores them or picks them up by mistake.

// File: rtl/ata_strobe_pkg.sv
package ata_strobe_pkg;
  localparam int WORD_W   = 32;
  localparam int CNT_W    = 5;
  localparam int DHI_LSB  = 0;
  localparam int DHI_W    = 4;
  localparam int DLO_LSB  = 4;
  localparam int DLO_W    = 5;
  localparam int RHI_LSB  = 9;
  localparam int RHI_W    = 4;
  localparam int RLO_LSB  = 13;
  localparam int RLO_W    = 5;
  localparam int DSU_LSB  = 22;
  localparam int DSU_W    = 3;
  localparam int RSU_LSB  = 25;
  localparam int RSU_W    = 3;
  localparam int EN_LSB   = 28;
  localparam int EN_W     = 4;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_ACTIVE,
    PH_RECOV
  } phase_t;

  typedef struct packed {
    logic capture;
    logic loadSetup;
    logic loadActive;
    logic loadRecov;
    logic strobeOn;
  } ctl_t;
endpackage

// File: rtl/ata_strobe_dp.sv
module ata_strobe_dp
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctl_t              ctl,
  input  logic              reqIsReg,
  input  logic              reqIsWrite,
  input  logic [WORD_W-1:0] timingWord,
  output logic              cntZero,
  output logic              curIsReg,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic [EN_W-1:0]   enables
);
  logic [WORD_W-1:0] curWord;
  logic              curIsWrite;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] srcWord;
  logic              srcIsReg;
  logic [CNT_W-1:0]  setupVal;
  logic [CNT_W-1:0]  activeVal;
  logic [CNT_W-1:0]  recovVal;
  logic [CNT_W-1:0]  loadVal;

  // A new request supplies its own word; later phases read the held copy.
  assign srcWord  = ctl.capture ? timingWord : curWord;
  assign srcIsReg = ctl.capture ? reqIsReg   : curIsReg;

  always_comb begin
    if (srcIsReg) begin
      setupVal  = CNT_W'(srcWord[RSU_LSB +: RSU_W]);
      activeVal = CNT_W'(srcWord[RLO_LSB +: RLO_W]);
      recovVal  = CNT_W'(srcWord[RHI_LSB +: RHI_W]);
    end else begin
      setupVal  = CNT_W'(srcWord[DSU_LSB +: DSU_W]);
      activeVal = CNT_W'(srcWord[DLO_LSB +: DLO_W]);
      recovVal  = CNT_W'(srcWord[DHI_LSB +: DHI_W]);
    end
  end

  always_comb begin
    loadVal = '0;
    if (ctl.loadSetup)  loadVal = setupVal;
    if (ctl.loadActive) loadVal = activeVal;
    if (ctl.loadRecov)  loadVal = recovVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curWord    <= '0;
      curIsReg   <= 1'b0;
      curIsWrite <= 1'b0;
    end else if (ctl.capture) begin
      curWord    <= timingWord;
      curIsReg   <= reqIsReg;
      curIsWrite <= reqIsWrite;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadSetup || ctl.loadActive || ctl.loadRecov) begin
      cnt <= loadVal;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero   = (cnt == '0);
  assign rdStrobeN = !(ctl.strobeOn && !curIsWrite);
  assign wrStrobeN = !(ctl.strobeOn &&  curIsWrite);
  assign enables   = curWord[EN_LSB +: EN_W];

  // Held word changes only on a capture strobe from control.
  assert_word_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.capture |=> $stable(curWord));
endmodule

// File: rtl/ata_strobe_ctl.sv
module ata_strobe_ctl
  import ata_strobe_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqIsReg,
  input  logic cntZero,
  input  logic curIsReg,
  output ctl_t ctl,
  output logic busy,
  output logic done
);
  phase_t state, stateNext;
  logic   accept;
  logic   skipSetup;

  assign done      = (state == PH_RECOV) && cntZero;
  assign busy      = (state != PH_IDLE) && !done;
  assign accept    = reqValid && ((state == PH_IDLE) || done);
  // Chained data after data goes straight to the active phase.
  assign skipSetup = (state == PH_RECOV) && !curIsReg && !reqIsReg;

  always_comb begin
    stateNext = state;
    ctl       = '0;
    ctl.capture  = accept;
    ctl.strobeOn = (state == PH_ACTIVE);
    unique case (state)
      PH_IDLE: begin
        if (accept) begin
          stateNext     = PH_SETUP;
          ctl.loadSetup = 1'b1;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          stateNext      = PH_ACTIVE;
          ctl.loadActive = 1'b1;
        end
      end
      PH_ACTIVE: begin
        if (cntZero) begin
          stateNext     = PH_RECOV;
          ctl.loadRecov = 1'b1;
        end
      end
      PH_RECOV: begin
        if (cntZero) begin
          if (accept && skipSetup) begin
            stateNext      = PH_ACTIVE;
            ctl.loadActive = 1'b1;
          end else if (accept) begin
            stateNext     = PH_SETUP;
            ctl.loadSetup = 1'b1;
          end else begin
            stateNext = PH_IDLE;
          end
        end
      end
      default: stateNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= PH_IDLE;
    else       state <= stateNext;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_setup_from_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (state == PH_IDLE) |=> (state != PH_ACTIVE));
endmodule

// File: rtl/ata_strobe_gen.sv
module ata_strobe_gen
  import ata_strobe_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqIsReg,
  input  logic              reqIsWrite,
  input  logic [WORD_W-1:0] timingWord,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              busy,
  output logic              done,
  output logic              udmaEn,
  output logic              dmaEn,
  output logic              pioMasterEn,
  output logic              fifoEn
);
  ctl_t            ctl;
  logic            cntZero;
  logic            curIsReg;
  logic [EN_W-1:0] enables;

  ata_strobe_ctl ctl_i (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqIsReg (reqIsReg),
    .cntZero  (cntZero),
    .curIsReg (curIsReg),
    .ctl      (ctl),
    .busy     (busy),
    .done     (done)
  );

  ata_strobe_dp dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqIsReg   (reqIsReg),
    .reqIsWrite (reqIsWrite),
    .timingWord (timingWord),
    .cntZero    (cntZero),
    .curIsReg   (curIsReg),
    .rdStrobeN  (rdStrobeN),
    .wrStrobeN  (wrStrobeN),
    .enables    (enables)
  );

  assign udmaEn      = enables[0];
  assign dmaEn       = enables[1];
  assign pioMasterEn = enables[2];
  assign fifoEn      = enables[3];

  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdStrobeN || wrStrobeN);

  assert_idle_high_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !done) |-> (rdStrobeN && wrStrobeN));

  assert_status_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable({fifoEn, pioMasterEn, dmaEn, udmaEn}));
endmodule

// File: tb/ata_strobe_gen_tb.sv
module ata_strobe_gen_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqIsReg = 1'b0;
  logic        reqIsWrite = 1'b0;
  logic [31:0] timingWord = '0;
  logic        rdStrobeN, wrStrobeN, busy, done;
  logic        udmaEn, dmaEn, pioMasterEn, fifoEn;
  int          checks = 0;
  int          failures = 0;

  always #10 clk = ~clk;

  ata_strobe_gen dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqIsReg(reqIsReg),
    .reqIsWrite(reqIsWrite), .timingWord(timingWord),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .busy(busy), .done(done),
    .udmaEn(udmaEn), .dmaEn(dmaEn), .pioMasterEn(pioMasterEn), .fifoEn(fifoEn)
  );

  function automatic logic [31:0] mkWord(input int dHi, dLo, rHi, rLo, dSu, rSu, udma, en);
    mkWord = {en[3:0], rSu[2:0], dSu[2:0], udma[3:0], rLo[4:0], rHi[3:0], dLo[4:0], dHi[3:0]};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Vector layout: {rdStrobeN, wrStrobeN, busy, done, fifo, pioMaster, dma, udma}
  function automatic logic [7:0] outVec();
    outVec = {rdStrobeN, wrStrobeN, busy, done, fifoEn, pioMasterEn, dmaEn, udmaEn};
  endfunction

  task automatic issue(input bit isReg, input bit isWrite, input logic [31:0] w);
    reqValid = 1'b1; reqIsReg = isReg; reqIsWrite = isWrite; timingWord = w;
    @(negedge clk);
  endtask

  // Checks one whole access, starting one cycle after acceptance; stops on the done cycle.
  task automatic observe(input bit isReg, input bit isWrite, input logic [31:0] w,
                         input bit skip, input int injectAt, input string req);
    int su = skip ? 0 : (isReg ? int'(w[27:25]) : int'(w[24:22])) + 1;
    int ac = (isReg ? int'(w[17:13]) : int'(w[8:4])) + 1;
    int rc = (isReg ? int'(w[12:9]) : int'(w[3:0])) + 1;
    int total = su + ac + rc;
    reqValid = 1'b0;
    timingWord = ~w;            // R10: scrambled after capture
    reqIsReg = !isReg;
    reqIsWrite = !isWrite;
    for (int i = 1; i <= total; i++) begin
      logic [7:0] exp;
      logic rdE, wrE, busyE, doneE;
      if (i == injectAt + 1) reqValid = 1'b0;
      rdE = 1'b1; wrE = 1'b1;
      if (i > su && i <= su + ac) begin
        rdE = isWrite; wrE = !isWrite;
      end
      doneE = (i == total);
      busyE = !doneE;
      exp = {rdE, wrE, busyE, doneE, w[31:28]};
      chk(outVec() == exp, req, $sformatf("cycle %0d", i), 32'(outVec()), 32'(exp));
      if (i == injectAt) begin
        reqValid = 1'b1; reqIsReg = !isReg; reqIsWrite = !isWrite;
      end
      if (i < total) @(negedge clk);
    end
  endtask

  task automatic goIdle(input logic [3:0] en, input string req);
    @(negedge clk);
    chk(outVec() == {4'b1100, en}, req, "idle", 32'(outVec()), 32'({4'b1100, en}));
  endtask

  task automatic testReset();
    chk(outVec() == 8'b1100_0000, "R1", "reset state", 32'(outVec()), 32'hC0);
  endtask

  task automatic testDataRead();      // R2 R3 R5 R6
    logic [31:0] w = mkWord(2, 3, 7, 9, 1, 5, 0, 0);
    issue(0, 0, w);
    observe(0, 0, w, 0, 0, "R2/R3/R5 data read");
    goIdle(4'h0, "R6");
  endtask

  task automatic testDataWrite();     // R6 R11
    logic [31:0] w = mkWord(4, 1, 2, 6, 2, 0, 15, 4'b1010);
    issue(0, 1, w);
    observe(0, 1, w, 0, 0, "R6/R11 data write");
    goIdle(4'b1010, "R11");
  endtask

  task automatic testRegAccess();     // R4 R5
    logic [31:0] w = mkWord(1, 1, 5, 4, 0, 3, 0, 4'b0101);
    issue(1, 0, w);
    observe(1, 0, w, 0, 0, "R4/R5 reg read");
    goIdle(4'b0101, "R4");
    issue(1, 1, w);
    observe(1, 1, w, 0, 0, "R4 reg write");
    goIdle(4'b0101, "R4");
  endtask

  task automatic testChain();         // R7 R8
    logic [31:0] w1 = mkWord(1, 2, 3, 3, 3, 2, 0, 4'b0001);
    logic [31:0] w2 = mkWord(0, 4, 1, 1, 6, 1, 0, 4'b0010);
    logic [31:0] w3 = mkWord(2, 2, 1, 2, 0, 2, 0, 4'b0100);
    issue(0, 0, w1);
    observe(0, 0, w1, 0, 0, "R7 first");
    issue(0, 1, w2);
    observe(0, 1, w2, 1, 0, "R8 data-data no setup");
    issue(1, 0, w3);
    observe(1, 0, w3, 0, 0, "R8 reg after data setup");
    goIdle(4'b0100, "R7");
  endtask

  task automatic testBusyIgnore();    // R9
    logic [31:0] w = mkWord(3, 3, 1, 1, 2, 1, 0, 4'b1100);
    issue(0, 0, w);
    observe(0, 0, w, 0, 2, "R9 setup inject");
    goIdle(4'b1100, "R9 no extra access");
    issue(0, 1, w);
    observe(0, 1, w, 0, 5, "R9 active inject");
    goIdle(4'b1100, "R9 no extra access");
  endtask

  task automatic testBounds();        // R2 R3 R5 boundaries
    logic [31:0] wMin = 32'h0;
    logic [31:0] wMax = mkWord(15, 31, 0, 0, 7, 0, 0, 0);
    issue(0, 0, wMin);
    observe(0, 0, wMin, 0, 0, "R2/R3 minimum");
    goIdle(4'h0, "R5");
    issue(0, 1, wMax);
    observe(0, 1, wMax, 0, 0, "R2/R3/R5 maximum");
    goIdle(4'h0, "R3");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDataRead();
    testDataWrite();
    testRegAccess();
    testChain();
    testBusyIgnore();
    testBounds();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule